// File: doc/BRIEF.md
# Power-Good Reset Generator with Hysteresis

This block turns two threshold comparator flags from a supply output into a clean active-low reset. One flag says the output is above the upper threshold (about 94% of nominal). The other says the output is below the lower threshold (about 90% of nominal). The channel declares its output good only after the upper flag has held continuously for an entry delay. It declares the output bad again only after the lower flag has held continuously for an exit delay. The entry delay is long, in the millisecond range. The exit delay is short, in the tens of microseconds.

Both delays are counted in clock cycles. A parameter chooses between two variants. In the fixed variant, both delays are parameters. In the programmable variant, both delays are a configuration value multiplied by a per-unit cycle count. In both variants the exit delay is never allowed below a minimum cycle count, which protects against resets triggered by transients. A disabled channel holds its reset asserted. The analog comparators and the open-drain output pad sit outside the block.

Top module: `pgood_reset_gen`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `rst_out_n` is 0.
- R2: From the bad state, `rst_out_n` rises on the clock edge that samples `above_hi` high for the Nth consecutive cycle, where N is the entry limit, and not earlier.
- R3: A cycle with `above_hi` low while in the bad state restarts the entry count from zero.
- R4: From the good state, `rst_out_n` falls on the clock edge that samples `below_lo` high for the Mth consecutive cycle, where M is the exit limit, and not earlier.
- R5: A cycle with `below_lo` low while in the good state restarts the exit count from zero.
- R6: `below_lo` has no effect in the bad state, and `above_hi` has no effect in the good state. With neither flag high, the state holds.
- R7: The clock edge that samples `enable` low drives `rst_out_n` to 0 and clears the count. Counting starts fresh once `enable` returns high.
- R8: In the programmable variant (PROG=1), the entry limit is `cfg_scale`*ENTRY_UNIT, with a floor of 1.
- R9: The exit limit is never below MIN_EXIT. In the programmable variant it is max(`cfg_scale`*EXIT_UNIT, MIN_EXIT).
- R10: In the fixed variant (PROG=0), the entry limit is ENTRY_CYC, the exit limit is max(EXIT_CYC, MIN_EXIT), and `cfg_scale` is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Channel enable; low forces reset out |
| cfg_scale | input | CFG_W | Delay scale value (programmable variant only) |
| above_hi | input | 1 | Output is above the upper threshold |
| below_lo | input | 1 | Output is below the lower threshold |
| rst_out_n | output | 1 | Active-low reset; high means power good |

## Verification
The bench builds two instances side by side with small cycle counts. The first is programmable, with a 3-bit scale, an entry unit of 4, an exit unit of 1 and a minimum exit of 3. The second is fixed, with an entry of 8 and a requested exit of 2, which the block clamps to 3. These small values let the bench sweep every scale value, so both the zero-scale floor and the exit clamp are exercised. For each scale value, the bench also tries every interruption position inside the shorter of the two windows. Every expected edge time comes from the limit arithmetic in the requirements.

// File: rtl/pgood_reset_gen.sv
module pgood_reset_gen #(
  parameter bit PROG       = 1'b1,
  parameter int CFG_W      = 8,
  parameter int CNT_W      = 30,
  parameter int ENTRY_CYC  = 200000,
  parameter int EXIT_CYC   = 2500,
  parameter int ENTRY_UNIT = 1250000,
  parameter int EXIT_UNIT  = 156,
  parameter int MIN_EXIT   = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [CFG_W-1:0] cfg_scale,
  input  logic             above_hi,
  input  logic             below_lo,
  output logic             rst_out_n
);

  localparam logic [CNT_W-1:0] MIN_X = CNT_W'(MIN_EXIT);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

  logic [CNT_W-1:0] ent_raw, ext_raw, ent_lim, ext_lim, lim, cnt;
  logic             good, cond, hit;

  generate
    if (PROG) begin : g_prog
      assign ent_raw = CNT_W'(cfg_scale) * CNT_W'(ENTRY_UNIT);
      assign ext_raw = CNT_W'(cfg_scale) * CNT_W'(EXIT_UNIT);
    end else begin : g_fixed
      logic unused_cfg;
      assign unused_cfg = ^cfg_scale;
      assign ent_raw = CNT_W'(ENTRY_CYC);
      assign ext_raw = CNT_W'(EXIT_CYC);
    end
  endgenerate

  assign ent_lim = (ent_raw == '0) ? ONE : ent_raw;
  assign ext_lim = (ext_raw < MIN_X) ? MIN_X : ext_raw;

  assign cond = good ? below_lo : above_hi;
  assign lim  = good ? ext_lim : ent_lim;
  assign hit  = cond && (({1'b0, cnt} + 1'b1) >= {1'b0, lim});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      good <= 1'b0;
      cnt  <= '0;
    end else if (!enable) begin
      good <= 1'b0;
      cnt  <= '0;
    end else if (!cond) begin
      cnt <= '0;
    end else if (hit) begin
      good <= !good;
      cnt  <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign rst_out_n = good;

endmodule

// File: rtl/pgood_reset_chk.sv
module pgood_reset_chk #(
  parameter int MIN_EXIT = 1
) (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic above_hi,
  input logic below_lo,
  input logic rst_out_n
);

  logic [15:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_run <= '0;
    else if (rst_out_n && below_lo && enable)
      low_run <= (low_run == 16'hFFFF) ? low_run : low_run + 16'd1;
    else low_run <= '0;
  end

  assert_disable_forces_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !rst_out_n);

  assert_rise_needs_above_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_out_n) |-> ($past(above_hi) && $past(enable)));

  assert_fall_needs_below_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_out_n) |-> ($past(below_lo) || !$past(enable)));

  assert_good_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_out_n && !below_lo && enable) |=> rst_out_n);

  assert_bad_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_out_n && !above_hi) |=> !rst_out_n);

  assert_exit_floor_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rst_out_n) && $past(enable)) |-> (int'(low_run) >= MIN_EXIT));

endmodule

bind pgood_reset_gen pgood_reset_chk #(.MIN_EXIT(MIN_EXIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable),
  .above_hi(above_hi), .below_lo(below_lo), .rst_out_n(rst_out_n)
);

// File: tb/sim_pgood_reset_gen.sv
module sim_pgood_reset_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic above = 1'b0;
  logic below = 1'b0;
  logic [2:0] cfg = 3'd0;
  logic out0, out1;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pgood_reset_gen #(.PROG(1'b1), .CFG_W(3), .CNT_W(8), .ENTRY_CYC(1), .EXIT_CYC(1),
    .ENTRY_UNIT(4), .EXIT_UNIT(1), .MIN_EXIT(3)) u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_scale(cfg),
    .above_hi(above), .below_lo(below), .rst_out_n(out0));

  pgood_reset_gen #(.PROG(1'b0), .CFG_W(3), .CNT_W(8), .ENTRY_CYC(8), .EXIT_CYC(2),
    .ENTRY_UNIT(1), .EXIT_UNIT(1), .MIN_EXIT(3)) u1 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_scale(cfg),
    .above_hi(above), .below_lo(below), .rst_out_n(out1));

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0b exp=%0b", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_ch();
    enable = 1'b0; above = 1'b0; below = 1'b0;
    step();
    chk(out0, 1'b0, "R7 u0 disabled");
    chk(out1, 1'b0, "R7 u1 disabled");
    enable = 1'b1;
  endtask

  task automatic enter(input int e0, input int e1, input string req);
    int mx = (e0 > e1) ? e0 : e1;
    above = 1'b1; below = 1'b0;
    for (int i = 1; i <= mx; i++) begin
      step();
      chk(out0, i >= e0, {req, " u0 entry"});
      chk(out1, i >= e1, {req, " u1 entry"});
    end
    above = 1'b0;
  endtask

  task automatic leave(input int x0, input int x1, input string req);
    int mx = (x0 > x1) ? x0 : x1;
    below = 1'b1; above = 1'b0;
    for (int i = 1; i <= mx; i++) begin
      step();
      chk(out0, i < x0, {req, " u0 exit"});
      chk(out1, i < x1, {req, " u1 exit"});
    end
    below = 1'b0;
  endtask

  initial begin
    #800000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int e0, x0, mn;
    step();
    chk(out0, 1'b0, "R1 u0 in reset");
    chk(out1, 1'b0, "R1 u1 in reset");
    rst_n = 1'b1;
    step();
    chk(out0, 1'b0, "R1 u0 after reset");
    chk(out1, 1'b0, "R1 u1 after reset");

    // R7: flags ignored while disabled
    enable = 1'b0; above = 1'b1;
    for (int i = 0; i < 12; i++) begin
      step();
      chk(out0, 1'b0, "R7 u0 held off");
      chk(out1, 1'b0, "R7 u1 held off");
    end

    for (int c = 0; c < 8; c++) begin
      cfg = 3'(c);
      e0 = (c * 4 == 0) ? 1 : c * 4;        // R8
      x0 = (c < 3) ? 3 : c;                 // R9
      mn = (e0 < 8) ? e0 : 8;
      // R3: entry interrupted after p cycles, with below_lo high (R6)
      for (int p = 0; p < mn; p++) begin
        clear_ch();
        above = 1'b1;
        for (int i = 0; i < p; i++) begin
          step();
          chk(out0, 1'b0, "R3 u0 pre");
          chk(out1, 1'b0, "R3 u1 pre");
        end
        above = 1'b0; below = 1'b1;
        step();
        chk(out0, 1'b0, "R6 u0 below ignored");
        chk(out1, 1'b0, "R6 u1 below ignored");
        enter(e0, 8, "R2 R8 R10");
      end
      // R6: good state holds with neither flag, and above_hi ignored
      above = 1'b0; below = 1'b0;
      step();
      above = 1'b1;
      step();
      chk(out0, 1'b1, "R6 u0 hold");
      chk(out1, 1'b1, "R6 u1 hold");
      above = 1'b0;
      // R5: exit interrupted after q cycles
      for (int q = 0; q < 3; q++) begin
        below = 1'b1;
        for (int i = 0; i < q; i++) begin
          step();
          chk(out0, 1'b1, "R5 u0 pre");
          chk(out1, 1'b1, "R5 u1 pre");
        end
        below = 1'b0;
        step();
        leave(x0, 3, "R4 R9 R10");
        enter(e0, 8, "R2");
      end
      // R7: disable while good
      enable = 1'b0;
      step();
      chk(out0, 1'b0, "R7 u0 drop");
      chk(out1, 1'b0, "R7 u1 drop");
      enable = 1'b1;
      enter(e0, 8, "R7 re-enable");
      leave(x0, 3, "R4");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule